// File: doc/BRIEF.md
# Interlaced Line-Block Selector

This block tells a video capture path whether the scan line now arriving belongs to the group of four lines that the host wants stored. It counts line-sync strobes from the start of each field, drops the two low bits of that count to get a block number, and latches the parity of the field at field sync. The block number and the field parity are compared with an 8-bit request: seven bits of block number and one field bit. On a match, a single flag goes high.

The request register is stepped by a one-cycle advance strobe and cleared by a clear strobe. It steps through the blocks of one field parity first and then moves to the other parity. A full picture can therefore be gathered one block per field, in order, so that every vertical line is reached. The flag is registered. It updates only at line or field boundaries, so a write-gating stage downstream never sees it change part-way through a line.

Top module: `line_block_sel`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, blk_hit_o is 0, the line count is 0, the field latch is even and the request is block 0 of the even field.
- R2: A field_sync_i strobe clears the line count to 0. Otherwise, each line_sync_i strobe adds one to it. When both strobes occur in the same cycle, the field strobe wins.
- R3: The current block number is the line count shifted right by 2, so lines 4k to 4k+3 form block k. blk_hit_o is 1 only when this block number equals the 7-bit request block and the latched field equals the request field bit.
- R4: At a field_sync_i strobe, field_odd_i is latched as the field parity (1 = odd, 0 = even). The request field bit uses the same encoding.
- R5: A blk_adv_i strobe adds one to the request block. From block BLOCKS_PER_FIELD-1 (71 by default) it goes to block 0 and flips the request field bit.
- R6: A blk_clr_i strobe sets the request to block 0 of the even field. Clear takes priority over an advance in the same cycle.
- R7: blk_hit_o changes only in the cycle after a line_sync_i or field_sync_i strobe. At that edge it is evaluated with the new line count and parity and the request held before the edge. Request changes made in mid-line show only at the next boundary.
- R8: If the line count is at its maximum (511) and another line strobe arrives with no field strobe, the counter saturates and is marked stale. blk_hit_o then stays 0 for every request until the next field_sync_i.
- R9: After 2*BLOCKS_PER_FIELD advance strobes (144 by default) from a cleared request, the request is back at block 0 of the even field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_sync_i | input | 1 | One-cycle strobe at each line start |
| field_sync_i | input | 1 | One-cycle strobe at each field start |
| field_odd_i | input | 1 | Parity of the starting field, sampled at field_sync_i (1 = odd) |
| blk_adv_i | input | 1 | One-cycle strobe that steps the requested block |
| blk_clr_i | input | 1 | One-cycle strobe that clears the request to block 0, even field |
| blk_hit_o | output | 1 | Current line lies in the requested block and field |

## Verification
Several rules are checked on every cycle: the flag is stable except after a boundary strobe, the count clears on field sync and steps on each line, the request steps and wraps correctly and flips parity at the wrap, clear wins over advance, and a stale count never gives a hit. Other behaviour shows only at the output across whole scenarios. The bench shows the exact block/parity match, field-over-line priority, the return to the start after 144 advances, and recovery from saturation at the next field. A late request change taking effect only one line later is also shown there.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic {
    FIELD_EVEN = 1'b0,
    FIELD_ODD  = 1'b1
  } field_e;

  function automatic field_e field_flip(input field_e f);
    return (f == FIELD_EVEN) ? FIELD_ODD : FIELD_EVEN;
  endfunction

endpackage

// File: rtl/lbs_line_counter.sv
module lbs_line_counter
  import lbs_pkg::*;
#(
  parameter int unsigned LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              field_sync_i,
  input  logic              field_odd_i,
  output logic [LINE_W-1:0] cnt_q_o,
  output logic              lost_q_o,
  output field_e            fld_q_o,
  output logic [LINE_W-1:0] cnt_d_o,
  output logic              lost_d_o,
  output field_e            fld_d_o
);

  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              lost_q, lost_d;
  field_e            fld_q, fld_d;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    fld_d  = fld_q;
    if (field_sync_i) begin
      cnt_d  = '0;
      lost_d = 1'b0;
      fld_d  = field_e'(field_odd_i);
    end else if (line_sync_i && !lost_q) begin
      // saturate instead of wrapping onto a valid block
      if (cnt_q == CNT_MAX) lost_d = 1'b1;
      else                  cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
      fld_q  <= FIELD_EVEN;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
      fld_q  <= fld_d;
    end
  end

  assign cnt_q_o  = cnt_q;
  assign lost_q_o = lost_q;
  assign fld_q_o  = fld_q;
  assign cnt_d_o  = cnt_d;
  assign lost_d_o = lost_d;
  assign fld_d_o  = fld_d;

endmodule

// File: rtl/lbs_req_reg.sv
module lbs_req_reg
  import lbs_pkg::*;
#(
  parameter int unsigned BLK_W            = 7,
  parameter int unsigned BLOCKS_PER_FIELD = 72
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [BLK_W-1:0] blk_o,
  output field_e           fld_o
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS_PER_FIELD - 1);

  logic [BLK_W-1:0] blk_q;
  field_e           fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      fld_q <= FIELD_EVEN;
    end else if (clr_i) begin
      blk_q <= '0;
      fld_q <= FIELD_EVEN;
    end else if (adv_i) begin
      if (blk_q == LAST_BLK) begin
        blk_q <= '0;
        fld_q <= field_flip(fld_q);
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end
  end

  assign blk_o = blk_q;
  assign fld_o = fld_q;

endmodule

// File: rtl/lbs_block_match.sv
module lbs_block_match
  import lbs_pkg::*;
#(
  parameter int unsigned BLK_W    = 7,
  parameter int unsigned LOW_BITS = 2,
  localparam int unsigned LINE_W  = BLK_W + LOW_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [LINE_W-1:0] cnt_i,
  input  logic              lost_i,
  input  field_e            fld_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  field_e            req_fld_i,
  output logic              hit_o
);

  logic [BLK_W-1:0] cur_blk;
  logic             match;
  logic             hit_q;

  assign cur_blk = cnt_i[LINE_W-1:LOW_BITS];
  assign match   = !lost_i && (cur_blk == req_blk_i) && (fld_i == req_fld_i);

  // flag moves only at a line or field boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hit_q <= 1'b0;
    else if (boundary_i) hit_q <= match;
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/line_block_sel.sv
module line_block_sel
  import lbs_pkg::*;
#(
  parameter int unsigned BLK_W            = 7,
  parameter int unsigned LOW_BITS         = 2,
  parameter int unsigned BLOCKS_PER_FIELD = 72
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_sync_i,
  input  logic field_sync_i,
  input  logic field_odd_i,
  input  logic blk_adv_i,
  input  logic blk_clr_i,
  output logic blk_hit_o
);

  localparam int unsigned LINE_W = BLK_W + LOW_BITS;

  logic [LINE_W-1:0] line_cnt, line_cnt_nxt;
  logic              line_lost, line_lost_nxt;
  field_e            fld_cur, fld_nxt;
  logic [BLK_W-1:0]  req_blk;
  field_e            req_fld;

  lbs_line_counter #(
    .LINE_W (LINE_W)
  ) i_line_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_sync_i  (line_sync_i),
    .field_sync_i (field_sync_i),
    .field_odd_i  (field_odd_i),
    .cnt_q_o      (line_cnt),
    .lost_q_o     (line_lost),
    .fld_q_o      (fld_cur),
    .cnt_d_o      (line_cnt_nxt),
    .lost_d_o     (line_lost_nxt),
    .fld_d_o      (fld_nxt)
  );

  lbs_req_reg #(
    .BLK_W            (BLK_W),
    .BLOCKS_PER_FIELD (BLOCKS_PER_FIELD)
  ) i_req_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (blk_adv_i),
    .clr_i  (blk_clr_i),
    .blk_o  (req_blk),
    .fld_o  (req_fld)
  );

  lbs_block_match #(
    .BLK_W    (BLK_W),
    .LOW_BITS (LOW_BITS)
  ) i_block_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (line_sync_i | field_sync_i),
    .cnt_i      (line_cnt_nxt),
    .lost_i     (line_lost_nxt),
    .fld_i      (fld_nxt),
    .req_blk_i  (req_blk),
    .req_fld_i  (req_fld),
    .hit_o      (blk_hit_o)
  );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int unsigned BLK_W            = 7,
  parameter int unsigned LOW_BITS         = 2,
  parameter int unsigned BLOCKS_PER_FIELD = 72,
  localparam int unsigned LINE_W          = BLK_W + LOW_BITS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_sync_i,
  input logic              field_sync_i,
  input logic              blk_adv_i,
  input logic              blk_clr_i,
  input logic              blk_hit_o,
  input logic [LINE_W-1:0] line_cnt,
  input logic              line_lost,
  input logic [BLK_W-1:0]  req_blk,
  input logic              req_fld
);

  localparam logic [LINE_W-1:0] CNT_MAX  = {LINE_W{1'b1}};
  localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(BLOCKS_PER_FIELD - 1);

  p_field_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_sync_i |=> (line_cnt == '0) && !line_lost);

  p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_sync_i && !field_sync_i && !line_lost && line_cnt != CNT_MAX)
      |=> line_cnt == $past(line_cnt) + 1'b1);

  p_req_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_adv_i && !blk_clr_i && req_blk != LAST_BLK)
      |=> (req_blk == $past(req_blk) + 1'b1) && $stable(req_fld));

  p_req_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_adv_i && !blk_clr_i && req_blk == LAST_BLK)
      |=> (req_blk == '0) && (req_fld != $past(req_fld)));

  p_clr_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_clr_i |=> (req_blk == '0) && !req_fld);

  p_hit_at_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_sync_i && !field_sync_i) |=> $stable(blk_hit_o));

  p_stale_no_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_lost |-> !blk_hit_o);

endmodule

bind line_block_sel lbs_checker #(
  .BLK_W            (BLK_W),
  .LOW_BITS         (LOW_BITS),
  .BLOCKS_PER_FIELD (BLOCKS_PER_FIELD)
) i_lbs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_sync_i  (line_sync_i),
  .field_sync_i (field_sync_i),
  .blk_adv_i    (blk_adv_i),
  .blk_clr_i    (blk_clr_i),
  .blk_hit_o    (blk_hit_o),
  .line_cnt     (line_cnt),
  .line_lost    (line_lost),
  .req_blk      (req_blk),
  .req_fld      (req_fld)
);

// File: tb/test_line_block_sel.sv
`timescale 1ns/1ps
module test_line_block_sel;

  localparam int BPF     = 72;
  localparam int CNT_MAX = 511;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic line_sync_i = 1'b0, field_sync_i = 1'b0, field_odd_i = 1'b0;
  logic blk_adv_i = 1'b0, blk_clr_i = 1'b0;
  logic blk_hit_o;

  int total = 0;
  int bad   = 0;

  // model state
  int m_cnt = 0;
  bit m_lost = 0;
  bit m_fld = 0;
  int m_rblk = 0;
  bit m_rfld = 0;
  bit m_hit = 0;

  always #5 clk_i = ~clk_i;

  line_block_sel i_line_block_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_sync_i  (line_sync_i),
    .field_sync_i (field_sync_i),
    .field_odd_i  (field_odd_i),
    .blk_adv_i    (blk_adv_i),
    .blk_clr_i    (blk_clr_i),
    .blk_hit_o    (blk_hit_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: blk_hit_o=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit want_hit(int cnt, bit lost, bit fld, int rblk, bit rfld);
    return !lost && ((cnt >> 2) == rblk) && (fld == rfld);
  endfunction

  // one clock with given strobes; starts and ends at a falling edge
  task automatic cyc(input bit ls, input bit fs, input bit fo,
                     input bit adv, input bit clr, input string tag);
    int  n_cnt;
    bit  n_lost, n_fld;
    line_sync_i = ls; field_sync_i = fs; field_odd_i = fo;
    blk_adv_i = adv; blk_clr_i = clr;
    n_cnt = m_cnt; n_lost = m_lost; n_fld = m_fld;
    if (fs) begin
      n_cnt = 0; n_lost = 0; n_fld = fo;
    end else if (ls && !m_lost) begin
      if (m_cnt == CNT_MAX) n_lost = 1;
      else                  n_cnt = m_cnt + 1;
    end
    if (ls || fs) m_hit = want_hit(n_cnt, n_lost, n_fld, m_rblk, m_rfld);
    if (clr) begin
      m_rblk = 0; m_rfld = 0;
    end else if (adv) begin
      if (m_rblk == BPF - 1) begin m_rblk = 0; m_rfld = !m_rfld; end
      else m_rblk = m_rblk + 1;
    end
    m_cnt = n_cnt; m_lost = n_lost; m_fld = n_fld;
    @(posedge clk_i);
    @(negedge clk_i);
    line_sync_i = 0; field_sync_i = 0; blk_adv_i = 0; blk_clr_i = 0;
    check(blk_hit_o, m_hit, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: blk_hit_o=%0b expected=done", blk_hit_o);
    summary();
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0a17);
    repeat (3) @(negedge clk_i);
    check(blk_hit_o, 1'b0, "R1 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(blk_hit_o, 1'b0, "R1 after reset");

    // R4: even field, request block 0 even -> hit
    cyc(0, 1, 0, 0, 0, "R4 even field hit");
    check(blk_hit_o, 1'b1, "R4 even field literal");
    cyc(0, 1, 1, 0, 0, "R4 odd field miss");
    check(blk_hit_o, 1'b0, "R4 odd field literal");

    // R3: request block 1, hit on lines 4..7 only
    cyc(0, 0, 0, 1, 0, "R5 advance to 1");
    cyc(0, 1, 0, 0, 0, "R3 line 0 miss");
    for (int i = 1; i <= 9; i++) cyc(1, 0, 0, 0, 0, "R3 line walk");
    check(blk_hit_o, 1'b0, "R3 line 9 miss");
    cyc(0, 1, 0, 0, 0, "R3 refield");
    for (int i = 1; i <= 4; i++) cyc(1, 0, 0, 0, 0, "R3 to line 4");
    check(blk_hit_o, 1'b1, "R3 line 4 hit");

    // R7: mid-line clear does not move flag until next line
    cyc(0, 0, 0, 0, 1, "R7 mid-line clear");
    check(blk_hit_o, 1'b1, "R7 held mid-line");
    cyc(0, 0, 0, 0, 0, "R7 idle");
    cyc(1, 0, 0, 0, 0, "R7 next line");
    check(blk_hit_o, 1'b0, "R7 updated at boundary");

    // R6: clear beats advance
    cyc(0, 0, 0, 1, 0, "R6 pre adv");
    cyc(0, 0, 0, 1, 1, "R6 clr with adv");
    cyc(0, 1, 0, 0, 0, "R6 block 0 even");
    check(blk_hit_o, 1'b1, "R6 clear priority");

    // R2: field strobe wins over line strobe
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R2 count up");
    check(blk_hit_o, 1'b0, "R2 line 8 miss");
    cyc(1, 1, 0, 0, 0, "R2 both strobes");
    check(blk_hit_o, 1'b1, "R2 field wins");

    // R5: wrap from last block to block 0 of odd field
    for (int i = 0; i < BPF; i++) cyc(0, 0, 0, 1, 0, "R5 advance");
    cyc(0, 1, 1, 0, 0, "R5 odd field");
    check(blk_hit_o, 1'b1, "R5 wrap flips field");
    cyc(0, 1, 0, 0, 0, "R5 even field");
    check(blk_hit_o, 1'b0, "R5 even misses after wrap");

    // R9: 144 advances return to start
    cyc(0, 0, 0, 0, 1, "R9 clear");
    for (int i = 0; i < 2 * BPF; i++) cyc(0, 0, 0, 1, 0, "R9 advance");
    cyc(0, 1, 0, 0, 0, "R9 even field");
    check(blk_hit_o, 1'b1, "R9 full cycle");

    // R8: saturation, no hit on stale count, recovery at field sync
    for (int i = 0; i < CNT_MAX + 1; i++) cyc(1, 0, 0, 0, 0, "R8 overrun");
    check(blk_hit_o, 1'b0, "R8 stale no hit");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, "R8 still stale");
    check(blk_hit_o, 1'b0, "R8 stays stale");
    cyc(0, 1, 0, 0, 0, "R8 recover");
    check(blk_hit_o, 1'b1, "R8 recovered at field");

    // random mix, checked against model every cycle (R3, R7)
    for (int i = 0; i < 4000; i++) begin
      bit ls, fs, fo, adv, clr;
      ls  = ($urandom % 4) == 0;
      fs  = ($urandom % 250) == 0;
      fo  = $urandom % 2;
      adv = ($urandom % 40) == 0;
      clr = ($urandom % 500) == 0;
      cyc(ls, fs, fo, adv, clr, "R3 random");
    end

    summary();
    $finish;
  end

endmodule